// File: doc/BRIEF.md
# Program Counter with Boot Vector Load

This block keeps the 13-bit instruction address for a small 8-bit processor core. When reset is released, it first reads a two-byte start address from the top two bytes of the address space. It then hands that address to the fetch path and raises a ready flag. From that point on it steps forward by one byte each time the core fetches an instruction or operand byte. A jump, a taken branch or an interrupt entry loads it with a new target instead.

The block drives the memory address at all times. During the start-up sequence it points at the two vector bytes. Afterwards it shows the current count. Memory is assumed to return the addressed byte in the same cycle. Instruction decoding and branch condition evaluation are done by the core; this block only sees the resulting strobes and target.

Top module: `pcount_boot`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the following cycle shows `ready_o` = 0 and `mem_addr_o` = 0x1FFE.
- R2: In the first cycle after reset release `mem_addr_o` is 0x1FFE, and in the second it is 0x1FFF.
- R3: At the end of the second start-up cycle the count is loaded with {bits 4..0 of the byte read at 0x1FFE, the byte read at 0x1FFF}, and bits 7..5 of the byte read at 0x1FFE are ignored.
- R4: `ready_o` rises in the third cycle after reset release and stays high until the next reset.
- R5: While `ready_o` is high, `mem_addr_o` equals the count, and `fetch_i` high (with `load_i` low) advances the count by one in the next cycle.
- R6: Advancing from 0x1FFF gives 0x0000.
- R7: While `ready_o` is high, `load_i` high makes the count equal to `target_i` in the next cycle.
- R8: When `load_i` and `fetch_i` are both high, the load takes effect and no increment is applied.
- R9: `fetch_i`, `load_i` and `target_i` have no effect while `ready_o` is low; the first address after ready is the vector.
- R10: While `ready_o` is high with neither strobe, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_i | input | 1 | Byte fetched at current address; advance |
| load_i | input | 1 | Load count from `target_i` |
| target_i | input | 13 | Jump, branch or interrupt target |
| mem_addr_o | output | 13 | Address presented to memory |
| mem_rdata_i | input | 8 | Byte returned by memory for `mem_addr_o` |
| ready_o | output | 1 | Start address loaded; normal operation |

## Verification
The embedded assertions check several properties on every cycle. While the flag is low, the address stays inside the two-byte vector window. The flag stays high once raised. Once ready, the next address follows the strobes: a load gives the target and wins over a fetch, a fetch gives the old value plus one with wraparound, and no strobe holds the value. Strobes before ready leave the count untouched.

Only the bench scenarios can show the following: the exact cycle order of the two vector reads, that the start address is assembled from the right bytes with the top three bits discarded, and that a second reset restarts the whole sequence with a new vector.

// File: rtl/pcv_pkg.sv
// Package: shared types for the boot-vector program counter.
// Assumes: nothing beyond IEEE 1800-2017.
package pcv_pkg;

    // Start-up phase: read vector high byte, read low byte, then run.
    typedef enum logic [1:0] {
        PH_VHI = 2'd0,
        PH_VLO = 2'd1,
        PH_RUN = 2'd2
    } boot_ph_t;

endpackage

// File: rtl/pcv_boot_seq.sv
// Module: pcv_boot_seq
// Walks the two-cycle vector read after reset and raises ready afterwards.
// Assumes: memory returns the addressed byte in the same cycle, and
// ADDR_W exceeds DATA_W by at most DATA_W bits.
module pcv_boot_seq
    import pcv_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output boot_ph_t          phase,
    output logic              vec_load,
    output logic [ADDR_W-1:0] vec_value,
    output logic              ready
);

    localparam int HI_USE = ADDR_W - DATA_W;

    boot_ph_t          phase_q;
    logic [HI_USE-1:0] hi_q;
    logic              ready_q;

    // Phase register: VHI -> VLO -> RUN, and stays in RUN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_VHI;
        end else begin
            case (phase_q)
                PH_VHI:  phase_q <= PH_VLO;
                PH_VLO:  phase_q <= PH_RUN;
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    // Capture the used bits of the high vector byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else if (phase_q == PH_VHI) begin
            hi_q <= mem_rdata[HI_USE-1:0];
        end
    end

    // Ready flag: set as the low byte is consumed, held until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (phase_q == PH_VLO) begin
            ready_q <= 1'b1;
        end
    end

    // Discard the unused high bits of the vector byte.
    generate
        if (HI_USE < DATA_W) begin : g_drop_hi
            logic unused_hi_bits;
            assign unused_hi_bits = ^mem_rdata[DATA_W-1:HI_USE];
        end
    endgenerate

    assign phase     = phase_q;
    assign vec_load  = (phase_q == PH_VLO);
    assign vec_value = {hi_q, mem_rdata};
    assign ready     = ready_q;

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q |=> ready_q) else $error("ready dropped");  // R4

    AST_READY_AFTER_VLO: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_VLO) |=> ready_q) else $error("ready late");  // R4

endmodule

// File: rtl/pcv_pc_reg.sv
// Module: pcv_pc_reg
// Holds the count: vector load at start-up, then load/increment/hold.
// Assumes: vec_load is high for exactly one cycle, before ready rises.
module pcv_pc_reg #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic              vec_load,
    input  logic [ADDR_W-1:0] vec_value,
    input  logic              fetch,
    input  logic              load,
    input  logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] pc
);

    localparam logic [ADDR_W-1:0] PC_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PC_LAST = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    // Next count: vector, then load over fetch, else hold.
    always_comb begin
        pc_d = pc_q;
        if (vec_load) begin
            pc_d = vec_value;
        end else if (ready) begin
            if (load) begin
                pc_d = target;
            end else if (fetch) begin
                pc_d = pc_q + PC_ONE;
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc = pc_q;

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && load) |=> (pc_q == $past(target))) else $error("load lost");  // R8

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fetch && !load && pc_q != PC_LAST) |=> (pc_q == $past(pc_q) + PC_ONE))
        else $error("bad step");  // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && fetch && !load && pc_q == PC_LAST) |=> (pc_q == '0))
        else $error("no wrap");  // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !fetch && !load) |=> $stable(pc_q)) else $error("drift");  // R10

    AST_EARLY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !vec_load) |=> $stable(pc_q)) else $error("early strobe");  // R9

endmodule

// File: rtl/pcv_addr_sel.sv
// Module: pcv_addr_sel
// Chooses the memory address: vector bytes during start-up, else the count.
// Assumes: the vector occupies the two highest addresses.
module pcv_addr_sel
    import pcv_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  boot_ph_t          phase,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = VEC_LO_ADDR - ADDR_W'(1);

    // Address select by phase.
    always_comb begin
        case (phase)
            PH_VHI:  addr = VEC_HI_ADDR;
            PH_VLO:  addr = VEC_LO_ADDR;
            default: addr = pc;
        endcase
    end

endmodule

// File: rtl/pcount_boot.sv
// Module: pcount_boot (top)
// Program counter that loads a start address from the top of memory
// after reset, then follows fetch and load strobes.
// Assumes: synchronous memory read path returns data in the same cycle.
module pcount_boot
    import pcv_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              ready_o
);

    boot_ph_t          phase;
    logic              vec_load;
    logic [ADDR_W-1:0] vec_value;
    logic              ready;
    logic [ADDR_W-1:0] pc;

    pcv_boot_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rdata (mem_rdata_i),
        .phase     (phase),
        .vec_load  (vec_load),
        .vec_value (vec_value),
        .ready     (ready)
    );

    pcv_pc_reg #(.ADDR_W(ADDR_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .vec_load  (vec_load),
        .vec_value (vec_value),
        .fetch     (fetch_i),
        .load      (load_i),
        .target    (target_i),
        .pc        (pc)
    );

    pcv_addr_sel #(.ADDR_W(ADDR_W)) u_sel (
        .phase (phase),
        .pc    (pc),
        .addr  (mem_addr_o)
    );

    assign ready_o = ready;

    AST_VECTOR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> (mem_addr_o[ADDR_W-1:1] == {(ADDR_W-1){1'b1}}))
        else $error("outside vector window");  // R2

    AST_LOAD_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && load_i) |=> (mem_addr_o == $past(target_i)))
        else $error("target not on bus");  // R7

endmodule

// File: tb/pcount_boot_bench.sv
module pcount_boot_bench;

    localparam int AW = 13;

    typedef struct {
        logic [AW-1:0] addr;
        logic          rdy;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_i = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] target_i = '0;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]    mem_rdata_i;
    logic          ready_o;

    logic [7:0] vec_hi = 8'h00;
    logic [7:0] vec_lo = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb_q[$];

    // model state
    int            m_st = 0;
    logic [AW-1:0] m_pc = '0;

    always #2 clk = ~clk;

    // memory model: vector bytes at the top, otherwise low address bits
    assign mem_rdata_i = (mem_addr_o == 13'h1FFE) ? vec_hi :
                         (mem_addr_o == 13'h1FFF) ? vec_lo : mem_addr_o[7:0];

    pcount_boot u_pcount_boot (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_i     (fetch_i),
        .load_i      (load_i),
        .target_i    (target_i),
        .mem_addr_o  (mem_addr_o),
        .mem_rdata_i (mem_rdata_i),
        .ready_o     (ready_o)
    );

    // driver: apply one cycle of inputs and push the expected outcome
    task automatic step(input logic rn, input logic f, input logic l,
                        input logic [AW-1:0] t, input string tag);
        exp_t e;
        rst_n = rn; fetch_i = f; load_i = l; target_i = t;
        if (!rn) begin
            m_st = 0;
            e.addr = 13'h1FFE; e.rdy = 1'b0;
        end else if (m_st == 0) begin
            m_st = 1;
            e.addr = 13'h1FFF; e.rdy = 1'b0;
        end else if (m_st == 1) begin
            m_st = 2;
            m_pc = {vec_hi[4:0], vec_lo};
            e.addr = m_pc; e.rdy = 1'b1;
        end else begin
            if (l)      m_pc = t;
            else if (f) m_pc = m_pc + 13'd1;
            e.addr = m_pc; e.rdy = 1'b1;
        end
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor: compare just after each edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (mem_addr_o !== e.addr || ready_o !== e.rdy) begin
                fails++;
                $display("FAIL %s: addr=%h ready=%b expected addr=%h ready=%b",
                         e.tag, mem_addr_o, ready_o, e.addr, e.rdy);
            end
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset with strobes toggling
        vec_hi = 8'hE3; vec_lo = 8'hFE;
        step(1'b0, 1'b1, 1'b0, 13'h0123, "R1");
        step(1'b0, 1'b0, 1'b1, 13'h0456, "R1");
        step(1'b0, 1'b1, 1'b1, 13'h0789, "R1");
        // R2 R9: vector cycles with strobes that must be ignored
        step(1'b1, 1'b1, 1'b1, 13'h0AAA, "R2_R9");
        step(1'b1, 1'b1, 1'b1, 13'h0AAA, "R3_R9");
        // R4: ready up, vector 0x03FE (top bits of 0xE3 dropped)
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R4_R5");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R5");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R5");
        step(1'b1, 1'b0, 1'b0, 13'h1555, "R10");
        step(1'b1, 1'b0, 1'b0, 13'h0555, "R10");
        step(1'b1, 1'b0, 1'b1, 13'h0842, "R7");
        step(1'b1, 1'b1, 1'b1, 13'h1234, "R8");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R5");
        step(1'b1, 1'b0, 1'b1, 13'h1FFD, "R7");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R5");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R5");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R6");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R6");
        step(1'b1, 1'b0, 1'b0, 13'h0000, "R4");
        // second reset: vector 0x1FFF, then wrap on first fetch
        vec_hi = 8'h1F; vec_lo = 8'hFF;
        step(1'b0, 1'b0, 1'b0, 13'h0000, "R1");
        step(1'b0, 1'b0, 1'b0, 13'h0000, "R1");
        step(1'b1, 1'b0, 1'b1, 13'h0111, "R2");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R2_R9");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R3_R4");
        step(1'b1, 1'b1, 1'b0, 13'h0000, "R6");
        step(1'b1, 1'b1, 1'b1, 13'h0FF0, "R8");
        step(1'b1, 1'b0, 1'b0, 13'h0000, "R10");
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule